// File: doc/BRIEF.md
# RMII Frame Receiver with Ping-Pong Frame Storage

This block takes Ethernet frames from a two-bit reduced media-independent interface. The interface is sampled once per reference-clock cycle, and each sample is one dibit plus the combined carrier/data-valid line. The receiver ignores any zero dibits that come before the preamble. It locks on at the first dibit with the low data bit set, checks that the preamble ends with the correct start delimiter, and packs the dibits into bytes. It runs a CRC-32 over the whole frame, including the frame check sequence, and writes the bytes into one of two frame stores.

Ownership of the two stores is tracked by a pair of free-running sequence counters. The receiver advances the put counter only after a frame passes its CRC check, and the frame's byte length is recorded at the same moment. The consumer reads the store that the parity of the get counter selects, then pulses `get_advance` to hand that store back. The difference between the two counters is the number of full stores: 0, 1 or 2. Frames with a bad delimiter, a bad CRC, a dangling partial byte or too many bytes advance an error counter instead.

Top module: `rmii_rx_pingpong`

## Requirements
- R1: After reset, `put_cnt`, `get_cnt` and `err_cnt` are zero. The receiver arms only after IPG_DIBITS consecutive samples with `crs_dv` low. A frame that starts before then is neither stored nor counted.
- R2: While `crs_dv` is high, any number of 2'b00 dibits before the preamble is skipped. The preamble starts at the first dibit whose `rxd[0]` is 1.
- R3: The last 16 dibits before the data must be fifteen 2'b01 dibits followed by 2'b11, which is 0x55 three times then 0xD5, least significant bit first. A longer run of 2'b01 is accepted. Any other dibit, or a 2'b11 after fewer than fifteen 2'b01 dibits, aborts the frame and adds 1 to `err_cnt`.
- R4: Dibit k of a data byte (k = 0..3, first received = 0) lands in bits 2k+1:2k. Data byte n is stored at store address n.
- R5: The CRC register starts at all ones and uses the reflected polynomial 0xEDB88320 over every data byte, FCS included. It must end at 0xDEBB20E3. On any other value, `err_cnt` rises by 1 and `put_cnt` is unchanged.
- R6: A run of fewer than 4 consecutive low `crs_dv` samples inside a frame neither ends the frame nor contributes data. The 4th consecutive low sample ends it. A frame that ends with a partial byte counts as an error.
- R7: A frame of exactly MAX_FRAME bytes (FCS included) is accepted. When byte MAX_FRAME+1 completes, the frame is aborted and `err_cnt` rises by 1.
- R8: Frame sequence number s (the value of `put_cnt` when the frame is accepted) goes to store s mod 2. `rd_len` is the stored byte length, FCS included, of store `get_cnt` mod 2. `rd_data` returns the byte at `rd_addr` of that store one clock after `rd_addr` is presented.
- R9: While `put_cnt - get_cnt` equals 2, no frame is received and no counter changes. After a store is released, the receiver re-arms after IPG_DIBITS quiet samples.
- R10: `get_advance` adds 1 to `get_cnt` only when `put_cnt` differs from `get_cnt`. When they are equal it has no effect.
- R11: After each frame, `crs_dv` must stay low for IPG_DIBITS consecutive samples before the receiver re-arms. A frame that starts earlier is ignored without counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one dibit per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 2 | Received dibit, bit 0 is the earlier bit |
| crs_dv | input | 1 | Combined carrier sense and data valid |
| get_advance | input | 1 | Consumer releases the store it has finished with |
| rd_addr | input | LEN_W | Byte address within the consumer's store |
| rd_data | output | 8 | Registered read byte |
| rd_len | output | LEN_W | Byte length of the frame in the consumer's store |
| put_cnt | output | CNT_W | Count of accepted frames (wrapping) |
| get_cnt | output | CNT_W | Count of released stores (wrapping) |
| err_cnt | output | ERR_W | Count of rejected frames (wrapping) |

## Verification
The bench builds the receiver with MAX_FRAME = 64, IPG_DIBITS = 16, CNT_W = 4 and ERR_W = 8. The short frame limit lets the bench send frames of exactly 64 and 65 bytes without long runs. The 4-bit sequence counters wrap during a sweep of twelve frames, and that sweep varies the number of leading zero dibits, the preamble length and the payload length. Every stored byte is compared against the frame the bench generated, and the bench computes each FCS with its own bitwise CRC.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

    typedef enum logic [2:0] {
        ST_GAP   = 3'd0,
        ST_HOLD  = 3'd1,
        ST_ARMED = 3'd2,
        ST_HUNT  = 3'd3,
        ST_SYNC  = 3'd4,
        ST_DATA  = 3'd5
    } rx_state_e;

    localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT    = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

    localparam logic [1:0]  DIB_PRE     = 2'b01;
    localparam logic [1:0]  DIB_SFD     = 2'b11;
    localparam int          PRE_DIBITS  = 15;
    localparam int          END_LOWS    = 4;

endpackage

// File: rtl/rmii_rx_crc_step.sv
module rmii_rx_crc_step
    import rmii_rx_pkg::*;
(
    input  logic [31:0] crc_in,
    input  logic [7:0]  byte_in,
    output logic [31:0] crc_out
);

    always_comb begin
        logic [31:0] c;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ byte_in[i]) begin
                c = (c >> 1) ^ CRC_POLY;
            end else begin
                c = c >> 1;
            end
        end
        crc_out = c;
    end

endmodule

// File: rtl/rmii_rx_frame.sv
module rmii_rx_frame
    import rmii_rx_pkg::*;
#(
    parameter int MAX_FRAME  = 1522,
    parameter int IPG_DIBITS = 16,
    parameter int LEN_W      = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rxd,
    input  logic             crs_dv,
    input  logic             room,
    output logic             wr_en,
    output logic [LEN_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             fin_ok,
    output logic             fin_err,
    output logic [LEN_W-1:0] fin_len
);

    localparam int RUN_W = $clog2(IPG_DIBITS + END_LOWS);

    typedef struct packed {
        rx_state_e        st;
        logic [3:0]       pre;
        logic [1:0]       ph;
        logic [RUN_W-1:0] run;
        logic [LEN_W-1:0] nbytes;
        logic [7:0]       acc;
        logic [31:0]      crc;
    } frm_s;

    frm_s q, d;

    logic [7:0]  byte_w;
    logic [31:0] crc_nxt;
    logic [3:0]  pre_base;
    logic        sync_go;
    logic        abort;

    assign byte_w   = {rxd, q.acc[7:2]};
    assign pre_base = (q.st == ST_SYNC) ? q.pre : 4'd0;

    rmii_rx_crc_step u_crc (
        .crc_in  (q.crc),
        .byte_in (byte_w),
        .crc_out (crc_nxt)
    );

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_addr = q.nbytes;
        wr_data = byte_w;
        fin_ok  = 1'b0;
        fin_err = 1'b0;
        fin_len = q.nbytes;
        sync_go = 1'b0;
        abort   = 1'b0;

        unique case (q.st)
            ST_GAP: begin
                if (crs_dv) begin
                    d.run = '0;
                end else if (q.run == RUN_W'(IPG_DIBITS - 1)) begin
                    d.run = '0;
                    d.st  = room ? ST_ARMED : ST_HOLD;
                end else begin
                    d.run = q.run + 1'b1;
                end
            end
            ST_HOLD: begin
                if (room) begin
                    d.st  = ST_GAP;
                    d.run = '0;
                end
            end
            ST_ARMED: begin
                if (crs_dv) begin
                    if (rxd[0]) sync_go = 1'b1;
                    else        d.st    = ST_HUNT;
                end
            end
            ST_HUNT: begin
                if (!crs_dv) begin
                    d.st  = ST_GAP;
                    d.run = '0;
                end else if (rxd[0]) begin
                    sync_go = 1'b1;
                end
            end
            ST_SYNC: begin
                if (!crs_dv) abort   = 1'b1;
                else         sync_go = 1'b1;
            end
            ST_DATA: begin
                if (crs_dv) begin
                    d.run = '0;
                    d.acc = byte_w;
                    d.ph  = q.ph + 2'd1;
                    if (q.ph == 2'd3) begin
                        if (q.nbytes == LEN_W'(MAX_FRAME)) begin
                            abort = 1'b1;
                        end else begin
                            wr_en    = 1'b1;
                            d.crc    = crc_nxt;
                            d.nbytes = q.nbytes + 1'b1;
                        end
                    end
                end else if (q.run == RUN_W'(END_LOWS - 1)) begin
                    if (q.ph == 2'd0 && q.crc == CRC_RESIDUE) begin
                        fin_ok = 1'b1;
                        d.st   = ST_GAP;
                        d.run  = '0;
                    end else begin
                        abort = 1'b1;
                    end
                end else begin
                    d.run = q.run + 1'b1;
                end
            end
            default: begin
                d.st  = ST_GAP;
                d.run = '0;
            end
        endcase

        if (sync_go) begin
            if (rxd == DIB_PRE) begin
                d.st  = ST_SYNC;
                d.pre = (pre_base == 4'(PRE_DIBITS)) ? pre_base : pre_base + 4'd1;
            end else if (rxd == DIB_SFD && pre_base == 4'(PRE_DIBITS)) begin
                d.st     = ST_DATA;
                d.pre    = '0;
                d.ph     = '0;
                d.run    = '0;
                d.nbytes = '0;
                d.acc    = '0;
                d.crc    = CRC_INIT;
            end else begin
                abort = 1'b1;
            end
        end

        if (abort) begin
            fin_err = 1'b1;
            wr_en   = 1'b0;
            d.st    = ST_GAP;
            d.run   = '0;
            d.pre   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_GAP;
            q.pre    <= '0;
            q.ph     <= '0;
            q.run    <= '0;
            q.nbytes <= '0;
            q.acc    <= '0;
            q.crc    <= CRC_INIT;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/rmii_rx_store.sv
module rmii_rx_store #(
    parameter int MAX_FRAME = 1522,
    parameter int CNT_W     = 8,
    parameter int ERR_W     = 16,
    parameter int LEN_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             fin_ok,
    input  logic             fin_err,
    input  logic [LEN_W-1:0] fin_len,
    input  logic             get_advance,
    input  logic [LEN_W-1:0] rd_addr,
    output logic [7:0]       rd_data,
    output logic [LEN_W-1:0] rd_len,
    output logic [CNT_W-1:0] put_cnt,
    output logic [CNT_W-1:0] get_cnt,
    output logic [ERR_W-1:0] err_cnt,
    output logic             room
);

    localparam int AW = $clog2(MAX_FRAME);

    typedef struct packed {
        logic [CNT_W-1:0]            put;
        logic [CNT_W-1:0]            get;
        logic [ERR_W-1:0]            err;
        logic [1:0][LEN_W-1:0]       len;
        logic                        rsel;
    } ctr_s;

    ctr_s q, d;

    logic [CNT_W-1:0] fill;
    logic             rd_in_range;
    logic [1:0][7:0]  bank_q;

    assign fill        = q.put - q.get;
    assign room        = (fill != CNT_W'(2));
    assign rd_in_range = (rd_addr < LEN_W'(MAX_FRAME));

    always_comb begin
        d      = q;
        d.rsel = q.get[0];
        if (fin_ok) begin
            d.len[q.put[0]] = fin_len;
            d.put           = q.put + 1'b1;
        end
        if (fin_err) begin
            d.err = q.err + 1'b1;
        end
        if (get_advance && (q.put != q.get)) begin
            d.get = q.get + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [7:0] mem [MAX_FRAME];

        always_ff @(posedge clk) begin
            if (wr_en && (q.put[0] == 1'(g))) begin
                mem[wr_addr[AW-1:0]] <= wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else if (rd_in_range) begin
                bank_q[g] <= mem[rd_addr[AW-1:0]];
            end else begin
                bank_q[g] <= '0;
            end
        end
    end

    assign rd_data = bank_q[q.rsel];
    assign rd_len  = q.len[q.get[0]];
    assign put_cnt = q.put;
    assign get_cnt = q.get;
    assign err_cnt = q.err;

endmodule

// File: rtl/rmii_rx_pingpong.sv
module rmii_rx_pingpong #(
    parameter int MAX_FRAME  = 1522,
    parameter int IPG_DIBITS = 16,
    parameter int CNT_W      = 8,
    parameter int ERR_W      = 16,
    localparam int LEN_W     = $clog2(MAX_FRAME + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rxd,
    input  logic             crs_dv,
    input  logic             get_advance,
    input  logic [LEN_W-1:0] rd_addr,
    output logic [7:0]       rd_data,
    output logic [LEN_W-1:0] rd_len,
    output logic [CNT_W-1:0] put_cnt,
    output logic [CNT_W-1:0] get_cnt,
    output logic [ERR_W-1:0] err_cnt
);

    logic             room_w;
    logic             wr_en_w;
    logic [LEN_W-1:0] wr_addr_w;
    logic [7:0]       wr_data_w;
    logic             fin_ok_w;
    logic             fin_err_w;
    logic [LEN_W-1:0] fin_len_w;

    rmii_rx_frame #(
        .MAX_FRAME  (MAX_FRAME),
        .IPG_DIBITS (IPG_DIBITS),
        .LEN_W      (LEN_W)
    ) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd     (rxd),
        .crs_dv  (crs_dv),
        .room    (room_w),
        .wr_en   (wr_en_w),
        .wr_addr (wr_addr_w),
        .wr_data (wr_data_w),
        .fin_ok  (fin_ok_w),
        .fin_err (fin_err_w),
        .fin_len (fin_len_w)
    );

    rmii_rx_store #(
        .MAX_FRAME (MAX_FRAME),
        .CNT_W     (CNT_W),
        .ERR_W     (ERR_W),
        .LEN_W     (LEN_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en_w),
        .wr_addr     (wr_addr_w),
        .wr_data     (wr_data_w),
        .fin_ok      (fin_ok_w),
        .fin_err     (fin_err_w),
        .fin_len     (fin_len_w),
        .get_advance (get_advance),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .rd_len      (rd_len),
        .put_cnt     (put_cnt),
        .get_cnt     (get_cnt),
        .err_cnt     (err_cnt),
        .room        (room_w)
    );

endmodule

// File: rtl/rmii_rx_checker.sv
module rmii_rx_checker #(
    parameter int CNT_W = 8,
    parameter int ERR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             get_advance,
    input logic             wr_en,
    input logic [CNT_W-1:0] put_cnt,
    input logic [CNT_W-1:0] get_cnt,
    input logic [ERR_W-1:0] err_cnt
);

    logic [CNT_W-1:0] fill;
    assign fill = put_cnt - get_cnt;

    // R9: never more than two full stores
    a_r9_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(2));

    // R9: nothing is written into a store while both are owned by the consumer
    a_r9_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CNT_W'(2)) |-> !wr_en);

    // R10: releasing with nothing to release leaves the get counter alone
    a_r10_get_hold_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (get_advance && put_cnt == get_cnt) |=> (get_cnt == $past(get_cnt)));

    // R8: the sequence counter moves by at most one per cycle
    a_r8_put_steps: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (put_cnt == $past(put_cnt) || put_cnt == $past(put_cnt) + 1'b1));

    // R5: a frame is either accepted or counted as an error, never both
    a_r5_ok_xor_err: assert property (@(posedge clk) disable iff (!rst_n)
        (put_cnt != $past(put_cnt)) |-> (err_cnt == $past(err_cnt)));

endmodule

bind rmii_rx_pingpong rmii_rx_checker #(
    .CNT_W (CNT_W),
    .ERR_W (ERR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .get_advance (get_advance),
    .wr_en       (wr_en_w),
    .put_cnt     (put_cnt),
    .get_cnt     (get_cnt),
    .err_cnt     (err_cnt)
);

// File: tb/tb_rmii_rx_pingpong.sv
`timescale 1ns/1ps
module tb_rmii_rx_pingpong;

    localparam int MAXF  = 64;
    localparam int IPG   = 16;
    localparam int CW    = 4;
    localparam int EW    = 8;
    localparam int LW    = $clog2(MAXF + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    rxd = 2'b00;
    logic          crs_dv = 1'b0;
    logic          get_advance = 1'b0;
    logic [LW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic [LW-1:0] rd_len;
    logic [CW-1:0] put_cnt;
    logic [CW-1:0] get_cnt;
    logic [EW-1:0] err_cnt;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] fb [0:127];
    int flen;

    always #4 clk = ~clk;

    rmii_rx_pingpong #(
        .MAX_FRAME  (MAXF),
        .IPG_DIBITS (IPG),
        .CNT_W      (CW),
        .ERR_W      (EW)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rxd         (rxd),
        .crs_dv      (crs_dv),
        .get_advance (get_advance),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .rd_len      (rd_len),
        .put_cnt     (put_cnt),
        .get_cnt     (get_cnt),
        .err_cnt     (err_cnt)
    );

    function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ 32'hEDB88320;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic make_frame(input int npay, input int seed);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < npay; i++) begin
            fb[i] = 8'((i * seed) + seed * 3 + 1);
            c = crc_upd(c, fb[i]);
        end
        c = ~c;
        for (int k = 0; k < 4; k++) fb[npay + k] = c[8*k +: 8];
        flen = npay + 4;
    endtask

    task automatic dib(input logic [1:0] v, input logic dv);
        @(negedge clk);
        rxd    = v;
        crs_dv = dv;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) dib(2'b00, 1'b0);
    endtask

    // sfd_mode: 0 good, 1 bad dibit 2'b10 in place of the delimiter
    task automatic tx(input int nzero, input int npre, input bit sfd_bad,
                      input int gap_at, input bit dribble);
        for (int i = 0; i < nzero; i++) dib(2'b00, 1'b1);
        for (int i = 0; i < npre; i++)  dib(2'b01, 1'b1);
        dib(sfd_bad ? 2'b10 : 2'b11, 1'b1);
        for (int n = 0; n < flen; n++) begin
            if (n == gap_at) begin
                dib(2'b00, 1'b0);
                dib(2'b00, 1'b0);
                dib(2'b00, 1'b0);
            end
            for (int k = 0; k < 4; k++) dib(fb[n][2*k +: 2], 1'b1);
        end
        if (dribble) dib(2'b01, 1'b1);
    endtask

    task automatic advance();
        @(negedge clk);
        get_advance = 1'b1;
        @(negedge clk);
        get_advance = 1'b0;
    endtask

    task automatic rd_byte(input int a, output int v);
        @(negedge clk);
        rd_addr = LW'(a);
        @(negedge clk);
        v = int'(rd_data);
    endtask

    task automatic chk_store(input string req);
        int v;
        chk({req, " length"}, int'(rd_len), flen);
        for (int n = 0; n < flen; n++) begin
            rd_byte(n, v);
            chk({req, " byte"}, v, int'(fb[n]));
        end
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        chk("R1 put after reset", int'(put_cnt), 0);
        chk("R1 get after reset", int'(get_cnt), 0);
        chk("R1 err after reset", int'(err_cnt), 0);
        rst_n = 1'b1;

        // R1: frame before the receiver has seen a quiet gap is ignored
        make_frame(10, 5);
        idle(5);
        tx(0, 15, 1'b0, -1, 1'b0);
        idle(24);
        chk("R1 early frame not stored", int'(put_cnt), 0);
        chk("R1 early frame not counted", int'(err_cnt), 0);

        // R2 R4 R8: leading zero dibits, byte packing, store 0
        make_frame(20, 7);
        tx(3, 15, 1'b0, -1, 1'b0);
        idle(24);
        chk("R2 frame accepted", int'(put_cnt), 1);
        chk("R5 no error", int'(err_cnt), 0);
        chk_store("R4 store0 content");

        // R3 long preamble, R6 short low run inside the frame
        make_frame(30, 11);
        tx(0, 27, 1'b0, 5, 1'b0);
        idle(24);
        chk("R6 short low run keeps frame", int'(put_cnt), 2);
        chk("R3 long preamble no error", int'(err_cnt), 0);

        // R9: both stores full, next frame is dropped silently
        make_frame(12, 3);
        tx(1, 15, 1'b0, -1, 1'b0);
        idle(24);
        chk("R9 full blocks put", int'(put_cnt), 2);
        chk("R9 full blocks err", int'(err_cnt), 0);

        // R8: second frame lives in store 1
        advance();
        chk("R10 get advanced", int'(get_cnt), 1);
        make_frame(30, 11);
        chk_store("R8 store1 content");
        advance();
        chk("R10 get advanced again", int'(get_cnt), 2);
        advance();
        chk("R10 advance while empty ignored", int'(get_cnt), 2);
        idle(24);

        // R5: corrupted payload
        make_frame(16, 9);
        fb[4] = fb[4] ^ 8'h10;
        tx(2, 15, 1'b0, -1, 1'b0);
        idle(24);
        chk("R5 bad crc counted", int'(err_cnt), 1);
        chk("R5 bad crc not stored", int'(put_cnt), 2);

        // R3: wrong delimiter dibit, then short preamble
        make_frame(16, 9);
        tx(0, 15, 1'b1, -1, 1'b0);
        idle(24);
        chk("R3 bad delimiter counted", int'(err_cnt), 2);
        tx(0, 14, 1'b0, -1, 1'b0);
        idle(24);
        chk("R3 short preamble counted", int'(err_cnt), 3);
        chk("R3 no store", int'(put_cnt), 2);

        // R6: trailing partial byte
        tx(0, 15, 1'b0, -1, 1'b1);
        idle(24);
        chk("R6 partial byte counted", int'(err_cnt), 4);
        chk("R6 partial byte not stored", int'(put_cnt), 2);

        // R7: exactly the maximum length
        make_frame(MAXF - 4, 13);
        tx(0, 15, 1'b0, -1, 1'b0);
        idle(24);
        chk("R7 max frame accepted", int'(put_cnt), 3);
        chk("R7 max frame no error", int'(err_cnt), 4);
        chk("R8 max frame length", int'(rd_len), MAXF);
        rd_byte(MAXF - 1, v);
        chk("R7 last byte", v, int'(fb[MAXF - 1]));

        // R7: one byte too many
        make_frame(MAXF - 3, 17);
        tx(0, 15, 1'b0, -1, 1'b0);
        idle(24);
        chk("R7 oversize counted", int'(err_cnt), 5);
        chk("R7 oversize not stored", int'(put_cnt), 3);

        // R11: second frame after a too-short gap is ignored
        advance();
        make_frame(18, 19);
        tx(0, 15, 1'b0, -1, 1'b0);
        idle(6);
        tx(0, 15, 1'b0, -1, 1'b0);
        idle(24);
        chk("R11 only first frame stored", int'(put_cnt), 4);
        chk("R11 ignored frame not counted", int'(err_cnt), 5);
        chk_store("R11 store1 content");
        advance();

        // R2 R3 R8: sweep of zero runs, preamble lengths, sizes; counters wrap
        for (int k = 0; k < 12; k++) begin
            make_frame(4 + k * 4, 21 + k);
            tx(k % 7, 15 + (k % 4), 1'b0, -1, 1'b0);
            idle(24);
            chk("R2 sweep put", int'(put_cnt), (5 + k) % 16);
            chk("R8 sweep err", int'(err_cnt), 5);
            chk_store("R8 sweep content");
            advance();
            chk("R10 sweep get", int'(get_cnt), (5 + k) % 16);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule